// File: doc/BRIEF.md
# Packed SIMD Rotate-Left Unit

This block rotates a 64-bit data operand to the left by counts taken from a second 64-bit operand. In packed (SIMD) mode the word is split into equal lanes of 8, 16, 32 or 64 bits. Each lane is rotated by its own count, which comes from the lane in the same position of the amount operand. Bits that leave the top of a lane come back in at the bottom of that same lane and never move into a neighbouring lane. The whole destination register is written back.

In scalar mode only the low-order operand of the selected width is rotated, using the count in the low bits of the amount operand. The bytes above that width read as zero, and a byte write-enable mask tells the register file to update only the low bytes of the destination.

The unit takes one cycle. It captures an operation when `issue_en` is high, and its outputs hold their value while `issue_en` is low. The reset is asynchronous and active-low; it is expected to be released synchronously by the reset logic outside the block.

Top module: `simd_rotl_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `wmask_o` are both zero.
- R2: An operation presented with `issue_en` high appears on the outputs after the next rising clock edge. While `issue_en` is low, the outputs keep their previous values.
- R3: `size_i` selects the lane width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 is 64 bits.
- R4: In SIMD mode (`simd_i`=1), lane i of `result_o` is lane i of `data_i` rotated left by the count in lane i of `amount_i`. The lane occupies bits [i*W +: W], where W is the lane width.
- R5: A lane's count uses only the low log2(W) bits of its lane field in `amount_i`. The higher bits of the field have no effect on the result.
- R6: A count of zero passes a lane through unchanged. A rotation never moves a bit across a lane boundary.
- R7: In SIMD mode, `wmask_o` is 8'hFF for every lane width.
- R8: In scalar mode (`simd_i`=0), bits [W-1:0] of `result_o` are `data_i[W-1:0]` rotated left by `amount_i[log2(W)-1:0]`, and all bits from W upward are zero.
- R9: In scalar mode, `wmask_o` enables only the bytes of the selected width: 8'h01, 8'h03, 8'h0F and 8'hFF for 8, 16, 32 and 64 bits. Bit b of the mask enables byte b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_en | input | 1 | Clock enable that captures a new operation |
| simd_i | input | 1 | 1 = packed lanes, 0 = scalar low-order operand |
| size_i | input | 2 | Lane or operand width code |
| data_i | input | 64 | Operand to rotate |
| amount_i | input | 64 | Rotate counts, one per lane |
| result_o | output | 64 | Rotated result, registered |
| wmask_o | output | 8 | Byte write-enable for the destination, registered |

## Verification
Each lane has its own count and its own rotator. A fault in one lane, or a count taken from the wrong bits, therefore shows up only in the result bytes of that lane, and only for operands where that lane's count differs from lane 0's count. For this reason the stimulus gives every lane a different count and fills the ignored high bits of each count field with nonzero values. All storage is the single output register, so any wrong state appears on the outputs in the cycle after the issue. The reference model is compared against the outputs on every clock, which catches such an error at once.

// File: rtl/simdrot_pkg.sv
package simdrot_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned BYTE_N  = WORD_W / 8;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_sz_e;

  // number of bytes covered by a scalar operand of the given width code
  function automatic int unsigned bytes_of(input lane_sz_e sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/simdrot_lane.sv
module simdrot_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] val_i,
  input  logic [LANE_W-1:0] cnt_field_i,
  output logic [LANE_W-1:0] val_o
);
  localparam int unsigned CNT_W = $clog2(LANE_W);

  logic [CNT_W-1:0]    cnt;
  logic [2*LANE_W-1:0] doubled;
  logic                unused_hi;

  assign cnt       = cnt_field_i[CNT_W-1:0];
  assign unused_hi = ^cnt_field_i[LANE_W-1:CNT_W];

  always_comb begin
    doubled = {val_i, val_i} << cnt;
    val_o   = doubled[2*LANE_W-1:LANE_W];
  end
endmodule

// File: rtl/simdrot_bank.sv
module simdrot_bank #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] amount_i,
  output logic [WORD_W-1:0] rot_o
);
  localparam int unsigned LANES = WORD_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simdrot_lane #(.LANE_W(LANE_W)) u_lane (
      .val_i       (data_i[g*LANE_W +: LANE_W]),
      .cnt_field_i (amount_i[g*LANE_W +: LANE_W]),
      .val_o       (rot_o[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simdrot_wmask.sv
module simdrot_wmask
  import simdrot_pkg::*;
#(
  parameter int unsigned BYTES = 8
) (
  input  logic        simd_i,
  input  lane_sz_e    size_i,
  output logic [BYTES-1:0] wmask_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign wmask_o[b] = simd_i || (b < bytes_of(size_i));
  end
endmodule

// File: rtl/simd_rotl_unit.sv
module simd_rotl_unit
  import simdrot_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic          simd_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] amount_i,
  output logic [DW-1:0] result_o,
  output logic [DW/8-1:0] wmask_o
);
  localparam int unsigned NB    = DW / 8;
  localparam int unsigned NSIZE = 4;

  lane_sz_e        sz;
  logic [DW-1:0]   rot_by_sz [NSIZE];
  logic [DW-1:0]   rot_sel;
  logic [NB-1:0]   wmask_d;
  logic [DW-1:0]   result_d;
  logic [DW-1:0]   result_q;
  logic [NB-1:0]   wmask_q;

  assign sz = lane_sz_e'(size_i);

  // one bank of lane rotators per lane width
  for (genvar s = 0; s < NSIZE; s++) begin : g_bank
    simdrot_bank #(.WORD_W(DW), .LANE_W(8 << s)) u_bank (
      .data_i   (data_i),
      .amount_i (amount_i),
      .rot_o    (rot_by_sz[s])
    );
  end

  simdrot_wmask #(.BYTES(NB)) u_wmask (
    .simd_i  (simd_i),
    .size_i  (sz),
    .wmask_o (wmask_d)
  );

  always_comb begin
    rot_sel = rot_by_sz[sz];
  end

  // scalar mode: bytes beyond the operand width read as zero
  for (genvar b = 0; b < NB; b++) begin : g_zero
    assign result_d[b*8 +: 8] = wmask_d[b] ? rot_sel[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      wmask_q  <= '0;
    end else if (issue_en) begin
      result_q <= result_d;
      wmask_q  <= wmask_d;
    end
  end

  assign result_o = result_q;
  assign wmask_o  = wmask_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |=> ($stable(result_o) && $stable(wmask_o)));

  // R7
  simd_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && simd_i) |=> (wmask_o == '1));

  // R9
  scalar_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && !simd_i && sz == LANE_8) |=> (wmask_o == NB'(1)));

  // R9
  mask_is_low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wmask_o & (wmask_o + NB'(1))) == '0));

  // R8
  scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && !simd_i && sz == LANE_16) |=> (result_o[DW-1:16] == '0));
endmodule

// File: tb/simd_rotl_unit_tb.sv
module simd_rotl_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        issue_en;
  logic        simd_i;
  logic [1:0]  size_i;
  logic [63:0] data_i;
  logic [63:0] amount_i;
  logic [63:0] result_o;
  logic [7:0]  wmask_o;

  int checks;
  int errors;
  bit done;

  logic [63:0] exp_res;
  logic [7:0]  exp_mask;
  string       exp_tag;

  simd_rotl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .simd_i(simd_i),
    .size_i(size_i), .data_i(data_i), .amount_i(amount_i),
    .result_o(result_o), .wmask_o(wmask_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] model_res(input logic [63:0] d, input logic [63:0] a,
                                            input bit simd, input int sz);
    int w = 8 << sz;
    int lanes = simd ? 64 / w : 1;
    logic [63:0] r = '0;
    for (int ln = 0; ln < lanes; ln++) begin
      int c = int'((a >> (ln * w)) & 64'(w - 1));
      for (int b = 0; b < w; b++)
        r[ln*w + b] = d[ln*w + ((b - c + w) % w)];
    end
    return r;
  endfunction

  function automatic logic [7:0] model_mask(input bit simd, input int sz);
    if (simd) return 8'hFF;
    return 8'((16'd1 << (1 << sz)) - 1);
  endfunction

  task automatic compare();
    checks++;
    if (result_o !== exp_res || wmask_o !== exp_mask) begin
      errors++;
      $display("FAIL %s: result=%h mask=%h expected result=%h mask=%h",
               exp_tag, result_o, wmask_o, exp_res, exp_mask);
    end
  endtask

  // drive at negedge, check the captured value at the following negedge
  task automatic op(input bit en, input bit simd, input int sz,
                    input logic [63:0] d, input logic [63:0] a, input string tag);
    issue_en = en; simd_i = simd; size_i = 2'(sz); data_i = d; amount_i = a;
    if (en) begin
      exp_res  = model_res(d, a, simd, sz);
      exp_mask = model_mask(simd, sz);
    end
    exp_tag = tag;
    @(negedge clk);
    compare();
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; issue_en = 0; simd_i = 0; size_i = 0; data_i = '0; amount_i = '0;
    exp_res = '0; exp_mask = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    issue_en = 1; simd_i = 1; data_i = '1; amount_i = 64'h0101010101010101;
    @(negedge clk);
    compare();   // R1: held at zero during reset even with issue_en high
    rst_n = 1'b1;
    issue_en = 0;
    @(negedge clk);
    compare();   // R1/R2 after release with no issue

    // R4 R3: per-lane counts, every width
    op(1, 1, 0, 64'h0123456789ABCDEF, 64'h0706050403020100, "R4 8-bit lanes");
    op(1, 1, 1, 64'h0123456789ABCDEF, 64'h000F000900040001, "R4 16-bit lanes");
    op(1, 1, 2, 64'h80000001DEADBEEF, 64'h0000001F00000008, "R4 32-bit lanes");
    op(1, 1, 3, 64'h8000000000000001, 64'h000000000000003F, "R3 64-bit lane");
    // R5: high bits of each count field ignored
    op(1, 1, 0, 64'hF0E1D2C3B4A59687, 64'hF8A9CB1273E4FD50, "R5 8-bit high count bits");
    op(1, 1, 2, 64'h1234567800FF00FF, 64'hFFFFFFE1ABCDEF00, "R5 32-bit high count bits");
    op(1, 1, 3, 64'h00000000000000C3, 64'hFFFFFFFFFFFFFFC4, "R5 64-bit high count bits");
    // R6: zero counts and lane-edge bits
    op(1, 1, 1, 64'hFEDCBA9876543210, 64'h0000000000000000, "R6 zero count");
    op(1, 1, 0, 64'h8080808080808080, 64'h0101010101010101, "R6 no lane crossing");
    // R7 R8 R9: scalar widths
    op(1, 0, 0, 64'hFFFFFFFFFFFFFF81, 64'hFFFFFFFFFFFFFF01, "R8 R9 scalar 8");
    op(1, 0, 1, 64'hAAAAAAAAAAAA8001, 64'h0000000000000004, "R8 R9 scalar 16");
    op(1, 0, 2, 64'h55555555F000000F, 64'h0000000000000024, "R8 R9 scalar 32");
    op(1, 0, 3, 64'h0123456789ABCDEF, 64'h0000000000000010, "R8 R9 scalar 64");
    // R2: hold while idle
    op(0, 1, 0, 64'h1111111111111111, 64'h0202020202020202, "R2 hold");
    op(0, 0, 1, 64'h2222222222222222, 64'h0303030303030303, "R2 hold");
    op(1, 1, 2, 64'h0000000100000001, 64'h0000000500000003, "R7 SIMD mask");
    // randomised mix
    for (int i = 0; i < 300; i++) begin
      op(($urandom % 4) != 0, $urandom % 2, $urandom % 4,
         {$urandom, $urandom}, {$urandom, $urandom}, "R4 R8 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule